// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block carries out the memory work of entering a real-mode interrupt handler once an 8-bit interrupt type is known. On a start pulse it captures the type together with the current flags, code segment, instruction pointer, stack segment and stack pointer. It then writes three words to the stack, in the order flags, CS and IP. Next it reads the handler's far pointer from the vector table in the lowest kilobyte of the address space.

Every access goes through one 16-bit memory port with a 20-bit byte address and a request/acknowledge handshake. When the second vector word arrives, the block pulses done for one cycle. In that cycle it presents the new CS:IP, the decremented SP and the flags word with interrupt-enable and trap cleared, ready for the surrounding core to load.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, done and mem_req are all low.
- R2: A start seen while idle makes busy high from the next cycle. Busy stays high up to and including the cycle in which done is high, and is low in the cycle after it.
- R3: A start that arrives while busy is ignored. The running sequence keeps the type and register values it captured, and no extra sequence follows.
- R4: Exactly three writes are made, in this order: flags, then CS, then IP. Before each write the stack pointer is reduced by 2. Each write goes to physical address (SS*16 + SP) mod 2^20, using the reduced SP.
- R5: The stack pointer wraps within 16 bits. A start with SP = 0x0000 writes the flags at offset 0xFFFE.
- R6: After the three writes, exactly two reads are made. The first reads the new IP from byte address type*4. The second reads the new CS from type*4 + 2. Both addresses lie in 0x00000..0x003FF.
- R7: Once mem_req is raised, it stays high, and mem_addr, mem_we and mem_wdata stay unchanged, until the cycle in which mem_ack is sampled high.
- R8: Done is high for exactly one cycle. In that cycle new_ip and new_cs equal the two words read, and new_sp equals the captured SP minus 6 (mod 2^16).
- R9: In the done cycle, new_flags equals the captured flags with bit 9 (interrupt enable) and bit 8 (trap) cleared and all other bits unchanged. The pushed flags word is the unmodified value.
- R10: The type, flags, CS, IP, SS and SP inputs are sampled only in the start cycle. Changing them later has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an entry sequence (idle only) |
| int_type | input | 8 | Interrupt type number |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer (return address) |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Byte address of the word access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when mem_ack is high |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 16 | Handler offset |
| new_sp | output | 16 | Stack pointer after the pushes |
| new_flags | output | 16 | Flags with interrupt enable and trap cleared |

## Verification
The assertions assume that mem_ack is high only while mem_req is high, and for one cycle per access. They also assume that mem_rdata is valid in the cycle where mem_ack is high. The bench memory model keeps to this. It waits a random zero to two cycles after a request, raises ack for a single cycle, and drops it in the next cycle. It returns read data that is a fixed function of the address. The stimulus drives start and the register inputs only at falling edges. It scrambles those inputs after each start so that late changes would show up in the results.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  int_type,
  input  logic [15:0] flags_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] ip_in,
  input  logic [15:0] ss_in,
  input  logic [15:0] sp_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack,
  output logic        busy,
  output logic        done,
  output logic [15:0] new_cs,
  output logic [15:0] new_ip,
  output logic [15:0] new_sp,
  output logic [15:0] new_flags
);
  typedef enum logic [2:0] {S_IDLE, S_PFL, S_PCS, S_PIP, S_RIP, S_RCS, S_DONE} st_t;
  localparam logic [15:0] CLR_MASK = 16'hFCFF;

  st_t         st;
  logic [7:0]  ty_r;
  logic [15:0] fl_r, cs_r, ip_r, ss_r, sp_r;
  logic        push;
  logic [15:0] sp_dec;

  assign push   = (st == S_PFL) || (st == S_PCS) || (st == S_PIP);
  assign sp_dec = sp_r - 16'd2;

  assign mem_req  = push || (st == S_RIP) || (st == S_RCS);
  assign mem_we   = push;
  assign mem_addr = push ? ({ss_r, 4'h0} + {4'h0, sp_dec})
                         : {10'h0, ty_r, (st == S_RCS), 1'b0};

  always_comb begin
    case (st)
      S_PFL:   mem_wdata = fl_r;
      S_PCS:   mem_wdata = cs_r;
      S_PIP:   mem_wdata = ip_r;
      default: mem_wdata = 16'h0;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign new_cs    = cs_r;
  assign new_ip    = ip_r;
  assign new_sp    = sp_r;
  assign new_flags = fl_r & CLR_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ty_r <= '0;
      fl_r <= '0;
      cs_r <= '0;
      ip_r <= '0;
      ss_r <= '0;
      sp_r <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ty_r <= int_type;
          fl_r <= flags_in;
          cs_r <= cs_in;
          ip_r <= ip_in;
          ss_r <= ss_in;
          sp_r <= sp_in;
          st   <= S_PFL;
        end
        S_PFL: if (mem_ack) begin sp_r <= sp_dec; st <= S_PCS; end
        S_PCS: if (mem_ack) begin sp_r <= sp_dec; st <= S_PIP; end
        S_PIP: if (mem_ack) begin sp_r <= sp_dec; st <= S_RIP; end
        S_RIP: if (mem_ack) begin ip_r <= mem_rdata; st <= S_RCS; end
        S_RCS: if (mem_ack) begin cs_r <= mem_rdata; st <= S_DONE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        mem_req,
  input logic        mem_we,
  input logic [19:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ack,
  input logic        busy,
  input logic        done,
  input logic [15:0] new_flags
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R6
  rd_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr < 20'h00400 && mem_addr[0] == 1'b0);

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_flags[9:8] == 2'b00);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .busy(busy),
  .done(done), .new_flags(new_flags)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  int_type = '0;
  logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        busy, done;
  logic [15:0] new_cs, new_ip, new_sp, new_flags;

  int checks = 0;
  int fails = 0;

  logic [19:0] wa [0:7];
  logic [15:0] wd [0:7];
  logic [19:0] ra [0:7];
  int wn = 0;
  int rn = 0;
  int rd_early = 0;

  always #5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .int_type(int_type),
    .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
    .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp), .new_flags(new_flags)
  );

  function automatic logic [15:0] tbl_word(input logic [19:0] a);
    return {a[9:0], 6'h15} ^ 16'h3C5A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin : mem_model
    int wt;
    wt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wt = int'($urandom % 3);
      end else if (mem_req && rst_n) begin
        if (wt == 0) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            if (wn < 8) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
            wn++;
          end else begin
            if (wn < 3) rd_early++;
            if (rn < 8) ra[rn] = mem_addr;
            mem_rdata = tbl_word(mem_addr);
            rn++;
          end
        end else wt--;
      end
    end
  end

  task automatic run(input logic [7:0] ty, input logic [15:0] fl, input logic [15:0] cs,
                     input logic [15:0] ip, input logic [15:0] ss, input logic [15:0] sp,
                     input bit late_start);
    logic [15:0] s;
    int n;
    wn = 0; rn = 0; rd_early = 0;
    @(negedge clk);
    int_type = ty; flags_in = fl; cs_in = cs; ip_in = ip; ss_in = ss; sp_in = sp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble inputs after capture
    int_type = ~ty; flags_in = $urandom; cs_in = $urandom; ip_in = $urandom;
    ss_in = $urandom; sp_in = $urandom;
    chk(busy == 1'b1, "R2", "busy after start", {31'b0, busy}, 1);
    n = 0;
    while (!done && n < 100) begin
      if (late_start && n == 2) begin start = 1'b1; int_type = ty ^ 8'h5A; end // R3
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R8", "done seen", {31'b0, done}, 1);
    chk(busy == 1'b1, "R2", "busy in done cycle", {31'b0, busy}, 1);
    chk(new_ip == tbl_word({10'h0, ty, 2'b00}), "R8", "new_ip", new_ip, tbl_word({10'h0, ty, 2'b00}));
    chk(new_cs == tbl_word({10'h0, ty, 2'b10}), "R8", "new_cs", new_cs, tbl_word({10'h0, ty, 2'b10}));
    chk(new_sp == sp - 16'd6, "R8", "new_sp", new_sp, sp - 16'd6);
    chk(new_flags == (fl & 16'hFCFF), "R9", "new_flags", new_flags, fl & 16'hFCFF);
    chk(wn == 3, "R4", "write count", wn, 3);
    chk(rn == 2, "R6", "read count", rn, 2);
    chk(rd_early == 0, "R6", "read before pushes", rd_early, 0);
    s = sp - 16'd2;
    chk(wa[0] == phys(ss, s) && wd[0] == fl, "R4", "flags push", {wa[0], 12'h0} | wd[0], {phys(ss, s), 12'h0} | fl);
    s = s - 16'd2;
    chk(wa[1] == phys(ss, s) && wd[1] == cs, "R4", "CS push", {wa[1], 12'h0} | wd[1], {phys(ss, s), 12'h0} | cs);
    s = s - 16'd2;
    chk(wa[2] == phys(ss, s) && wd[2] == ip, "R4", "IP push", {wa[2], 12'h0} | wd[2], {phys(ss, s), 12'h0} | ip);
    chk(ra[0] == {10'h0, ty, 2'b00}, "R6", "IP vector addr", ra[0], {10'h0, ty, 2'b00});
    chk(ra[1] == {10'h0, ty, 2'b10}, "R6", "CS vector addr", ra[1], {10'h0, ty, 2'b10});
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", {31'b0, done}, 0);
    chk(busy == 1'b0, "R2", "busy after done", {31'b0, busy}, 0);
    if (late_start) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b0 && mem_req == 1'b0, "R3", "no extra sequence", {busy, mem_req}, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1
    chk(busy == 0 && done == 0 && mem_req == 0, "R1", "reset outputs", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R1", "idle after reset", {busy, mem_req}, 0);
    run(8'h13, 16'hF3D5, 16'h1234, 16'h5678, 16'h2000, 16'h0100, 0);
    run(8'h00, 16'h0300, 16'hAAAA, 16'h5555, 16'h3000, 16'h0000, 0); // R5 SP wrap
    run(8'hFF, 16'hFFFF, 16'h0001, 16'hFFFE, 16'hFFFF, 16'h0020, 0); // R4 20-bit wrap
    run(8'h02, 16'h0000, 16'h0F0F, 16'hF0F0, 16'h0800, 16'h0004, 0); // R5 partial wrap
    run(8'h21, 16'h0246, 16'hC000, 16'h0010, 16'h9000, 16'hFFFE, 1); // R3
    for (int i = 0; i < 40; i++)
      run($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, (i % 5) == 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule